// File: doc/BRIEF.md
# Bit-Serial HDLC Frame Transmitter with Selectable Check Sequence

This block turns byte messages into a bit-serial HDLC stream for one data link channel. It takes bytes from a show-ahead FIFO. The FIFO marks the first byte of a message with `fifo_sof` and the last byte with `fifo_eof`. The block encloses each message between flag octets (0x7E) and applies zero-bit insertion to the frame body. It sends flags for as long as no message is waiting. The line side asks for bits with a one-cycle strobe `bit_req`, and each strobe produces exactly one output bit.

The `fcs_en` input selects the framing mode for each frame. With `fcs_en` set, the block computes a 16-bit check sequence over the message and appends it by itself; the check sequence never goes through the FIFO. With `fcs_en` clear, the frame body is exactly the bytes the processor queued, so software can build and check the whole frame itself. An abort octet (0xFF) ends a frame early. It is sent when software pulses `abort_req`, or when the FIFO runs dry before the last byte of a message.

Top module: `hdlc_tx_framer`

## Requirements
- R1: Each cycle with `bit_req` high produces one bit on `tx_bit`, with `tx_vld` high in the following cycle. `tx_vld` is low after every cycle without a request. With no message pending, the stream is back-to-back flag octets 0x7E.
- R2: Inside frame data and check sequence bits, a 0 is inserted after every run of five consecutive 1s, including a run that ends the last check sequence bit. Flag and abort octets are never stuffed and do not count toward a run.
- R3: A frame starts only after a completed flag, with a FIFO head byte whose `fifo_sof` is 1. Bytes go out in FIFO order, least significant bit first. A byte is popped (`fifo_rd` high for one cycle) in the cycle its first bit is requested. `fifo_rd` is never high while `fifo_empty` is high.
- R4: FCS mode: after the byte marked `fifo_eof`, two check octets follow, low octet first, each least significant bit first. The check value is the ones complement of a CRC over the data bytes. The CRC uses x^16+x^12+x^5+1 in bit-reversed form (0x8408), processed LSB first from a preset of 0xFFFF. A closing flag follows. No FIFO pop happens while check octets are sent.
- R5: Non-FCS mode: the closing flag follows the `fifo_eof` byte directly, and no extra octets are added.
- R6: `fcs_en` is sampled when the first byte of a frame is taken. Changing it later in that frame has no effect on that frame.
- R7: If the FIFO is empty when the next body byte of an open frame is due, an abort octet 0xFF is sent in place of that byte. At least one flag is sent before any new frame starts.
- R8: A one-cycle `abort_req` pulse makes the next octet an abort octet 0xFF. Any pending stuffed zero goes out first. The open frame is dropped and the block returns to idle flags.
- R9: While idle, a FIFO head byte with `fifo_sof` = 0 is popped and discarded at a flag boundary and never appears on the line.
- R10: During reset `tx_vld` and `fifo_rd` are low. The first octet after reset is a flag, even if a message is already waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fcs_en | input | 1 | 1: append generated check sequence; 0: body comes entirely from the FIFO |
| abort_req | input | 1 | One-cycle request to send an abort octet |
| bit_req | input | 1 | Strobe asking for the next line bit |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_sof | input | 1 | Head byte is the first byte of a message |
| fifo_eof | input | 1 | Head byte is the last byte of a message |
| fifo_data | input | 8 | Head byte (show-ahead) |
| fifo_rd | output | 1 | Pops the head byte at this clock edge |
| tx_bit | output | 1 | Serial line bit |
| tx_vld | output | 1 | `tx_bit` carries a new bit this cycle |

## Verification
The hardest case to reach is an abort that arrives while a frame is in mid-flight, because the request must land after the frame has started and before its closing flag. The stimulus fills the FIFO with a long message, watches the pop count, and raises `abort_req` once several bytes have left. It then confirms that the remaining bytes of that message are discarded and that the next message is framed correctly. The other hard case is a run of five 1s that meets a check octet edge or the closing flag. This case is reached with messages of all-ones bytes and bytes equal to the flag pattern, mixed into random frames with a biased byte mix and gaps of varying density in the bit request strobe.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  localparam logic [15:0] FCS_POLY_REV = 16'h8408;
  localparam logic [15:0] FCS_PRESET   = 16'hFFFF;

  typedef enum logic [1:0] {
    OK_FLAG,
    OK_ABORT,
    OK_DATA,
    OK_FCS
  } oct_kind_t;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_BODY,
    FS_FCS_LO,
    FS_FCS_HI
  } frm_state_t;

  // Advance the reflected CRC register over one byte, least significant bit first.
  function automatic logic [15:0] fcs_byte_step(input logic [15:0] crc_in,
                                                input logic [7:0]  d);
    logic [15:0] c;
    logic        fb;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ d[i];
      c  = {1'b0, c[15:1]};
      if (fb) c = c ^ FCS_POLY_REV;
    end
    return c;
  endfunction

  // Octet kinds that take part in zero insertion.
  function automatic logic is_stuffable(input oct_kind_t k);
    return (k == OK_DATA) || (k == OK_FCS);
  endfunction

endpackage

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs
  import hdlc_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upd,
  input  logic        start,
  input  logic [7:0]  din,
  output logic [15:0] crc
);

  logic [15:0] seed;

  assign seed = start ? FCS_PRESET : crc;

  always_ff @(posedge clk) begin
    if (!rst_n)   crc <= FCS_PRESET;
    else if (upd) crc <= fcs_byte_step(seed, din);
  end

endmodule

// File: rtl/hdlc_tx_seq.sv
module hdlc_tx_seq
  import hdlc_tx_pkg::*;
#(
  parameter logic [7:0] FLAG_PAT  = 8'h7E,
  parameter logic [7:0] ABORT_PAT = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        need_oct,
  input  oct_kind_t   cur_kind,
  input  logic        fifo_empty,
  input  logic        fifo_sof,
  input  logic        fifo_eof,
  input  logic [7:0]  fifo_data,
  input  logic        fcs_en,
  input  logic        abort_req,
  input  logic [15:0] crc,
  output logic [7:0]  ld_byte,
  output oct_kind_t   ld_kind,
  output logic        fifo_rd,
  output logic        crc_upd,
  output logic        crc_start,
  output frm_state_t  st,
  output logic        abort_pend
);

  frm_state_t st_n;
  logic       fcs_q, fcs_n;
  logic       take, rd_raw;

  always_comb begin
    ld_byte   = FLAG_PAT;
    ld_kind   = OK_FLAG;
    rd_raw    = 1'b0;
    take      = 1'b0;
    crc_start = 1'b0;
    st_n      = st;
    fcs_n     = fcs_q;
    if (abort_pend) begin
      ld_byte = ABORT_PAT;
      ld_kind = OK_ABORT;
      st_n    = FS_IDLE;
    end else begin
      unique case (st)
        FS_IDLE: begin
          if (!fifo_empty) begin
            if (!fifo_sof) begin
              rd_raw = 1'b1;                  // stray byte outside a message
            end else if (cur_kind == OK_FLAG) begin
              take      = 1'b1;
              crc_start = 1'b1;
              fcs_n     = fcs_en;             // mode fixed for the whole frame
            end
          end
        end
        FS_BODY: begin
          if (fifo_empty) begin
            ld_byte = ABORT_PAT;
            ld_kind = OK_ABORT;
            st_n    = FS_IDLE;
          end else begin
            take = 1'b1;
          end
        end
        FS_FCS_LO: begin
          ld_byte = ~crc[7:0];
          ld_kind = OK_FCS;
          st_n    = FS_FCS_HI;
        end
        FS_FCS_HI: begin
          ld_byte = ~crc[15:8];
          ld_kind = OK_FCS;
          st_n    = FS_IDLE;
        end
      endcase
      if (take) begin
        ld_byte = fifo_data;
        ld_kind = OK_DATA;
        rd_raw  = 1'b1;
        if (!fifo_eof)  st_n = FS_BODY;
        else if (fcs_n) st_n = FS_FCS_LO;
        else            st_n = FS_IDLE;
      end
    end
  end

  assign fifo_rd = need_oct & rd_raw;
  assign crc_upd = need_oct & take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= FS_IDLE;
      fcs_q      <= 1'b0;
      abort_pend <= 1'b0;
    end else begin
      if (need_oct) begin
        st    <= st_n;
        fcs_q <= fcs_n;
      end
      if (abort_req)     abort_pend <= 1'b1;
      else if (need_oct) abort_pend <= 1'b0;
    end
  end

endmodule

// File: rtl/hdlc_tx_ser.sv
module hdlc_tx_ser
  import hdlc_tx_pkg::*;
#(
  parameter int RUN_LEN = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_req,
  input  logic [7:0] ld_byte,
  input  oct_kind_t  ld_kind,
  output logic       need_oct,
  output logic       stuff_now,
  output oct_kind_t  cur_kind,
  output logic       tx_bit,
  output logic       tx_vld
);

  localparam int OW = 8;
  localparam int CW = $clog2(OW);
  localparam int RW = $clog2(RUN_LEN + 1);

  logic [OW-1:0] sh;
  logic [CW-1:0] cnt;
  logic [RW-1:0] ones;
  logic          run_full;
  oct_kind_t     emit_kind;
  logic          emit_bit;

  assign run_full  = (ones == RW'(RUN_LEN));
  assign stuff_now = bit_req & run_full;
  assign need_oct  = bit_req & ~run_full & (cnt == '0);
  assign emit_kind = need_oct ? ld_kind : cur_kind;

  always_comb begin
    if (run_full)      emit_bit = 1'b0;
    else if (need_oct) emit_bit = ld_byte[0];
    else               emit_bit = sh[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh       <= '0;
      cnt      <= '0;
      ones     <= '0;
      cur_kind <= OK_ABORT;   // no flag sent yet: forces a flag first
      tx_bit   <= 1'b0;
      tx_vld   <= 1'b0;
    end else begin
      tx_vld <= bit_req;
      if (bit_req) begin
        tx_bit <= emit_bit;
        if (run_full) begin
          ones <= '0;
        end else begin
          if (need_oct) begin
            sh       <= {1'b0, ld_byte[OW-1:1]};
            cnt      <= CW'(OW - 1);
            cur_kind <= ld_kind;
          end else begin
            sh  <= {1'b0, sh[OW-1:1]};
            cnt <= cnt - CW'(1);
          end
          if (is_stuffable(emit_kind) && emit_bit) ones <= ones + RW'(1);
          else                                     ones <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int         RUN_LEN   = 5,
  parameter logic [7:0] FLAG_PAT  = 8'h7E,
  parameter logic [7:0] ABORT_PAT = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fcs_en,
  input  logic       abort_req,
  input  logic       bit_req,
  input  logic       fifo_empty,
  input  logic       fifo_sof,
  input  logic       fifo_eof,
  input  logic [7:0] fifo_data,
  output logic       fifo_rd,
  output logic       tx_bit,
  output logic       tx_vld
);

  logic        need_oct;
  logic        stuff_now;
  oct_kind_t   cur_kind;
  logic [7:0]  ld_byte;
  oct_kind_t   ld_kind;
  logic        crc_upd, crc_start;
  logic [15:0] crc_q;
  frm_state_t  st;
  logic        abort_pend;

  hdlc_tx_seq #(
    .FLAG_PAT  (FLAG_PAT),
    .ABORT_PAT (ABORT_PAT)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .need_oct   (need_oct),
    .cur_kind   (cur_kind),
    .fifo_empty (fifo_empty),
    .fifo_sof   (fifo_sof),
    .fifo_eof   (fifo_eof),
    .fifo_data  (fifo_data),
    .fcs_en     (fcs_en),
    .abort_req  (abort_req),
    .crc        (crc_q),
    .ld_byte    (ld_byte),
    .ld_kind    (ld_kind),
    .fifo_rd    (fifo_rd),
    .crc_upd    (crc_upd),
    .crc_start  (crc_start),
    .st         (st),
    .abort_pend (abort_pend)
  );

  hdlc_tx_fcs u_fcs (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (crc_upd),
    .start (crc_start),
    .din   (fifo_data),
    .crc   (crc_q)
  );

  hdlc_tx_ser #(
    .RUN_LEN (RUN_LEN)
  ) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_req   (bit_req),
    .ld_byte   (ld_byte),
    .ld_kind   (ld_kind),
    .need_oct  (need_oct),
    .stuff_now (stuff_now),
    .cur_kind  (cur_kind),
    .tx_bit    (tx_bit),
    .tx_vld    (tx_vld)
  );

endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk
  import hdlc_tx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bit_req,
  input logic       fifo_empty,
  input logic       fifo_rd,
  input logic       tx_bit,
  input logic       tx_vld,
  input logic       need_oct,
  input logic       stuff_now,
  input oct_kind_t  cur_kind,
  input frm_state_t st,
  input logic       abort_pend
);

  // R1: one output bit for each strobe, one cycle later
  p_bit_per_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_req |=> tx_vld);
  p_quiet_no_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_req |=> !tx_vld);

  // R2: an inserted bit is a zero on the line
  p_stuff_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_now |=> (tx_vld && !tx_bit));

  // R3: no pop from an empty FIFO
  p_no_pop_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);

  // R4: check octets are never taken from the FIFO
  p_fcs_no_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (need_oct && !abort_pend && (st == FS_FCS_LO || st == FS_FCS_HI)) |-> !fifo_rd);

  // R7: an empty FIFO mid-body turns into an abort octet
  p_underrun_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (need_oct && st == FS_BODY && fifo_empty) |=> (cur_kind == OK_ABORT));

  // R7: no data octet directly after an abort octet
  p_flag_after_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (need_oct && cur_kind == OK_ABORT) |=> (cur_kind != OK_DATA));

  // R8: a pending abort request is honoured at the next octet boundary
  p_abort_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (need_oct && abort_pend) |=> (cur_kind == OK_ABORT));

  // R10: quiet outputs while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r10: assert (!fifo_rd);
    end
  end

endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_req    (bit_req),
  .fifo_empty (fifo_empty),
  .fifo_rd    (fifo_rd),
  .tx_bit     (tx_bit),
  .tx_vld     (tx_vld),
  .need_oct   (need_oct),
  .stuff_now  (stuff_now),
  .cur_kind   (cur_kind),
  .st         (st),
  .abort_pend (abort_pend)
);

// File: tb/sim_hdlc_tx_framer.sv
`timescale 1ns/1ps
module sim_hdlc_tx_framer;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       fcs_en = 1'b0;
  logic       abort_req = 1'b0;
  logic       bit_req = 1'b0;
  logic       fifo_empty, fifo_sof, fifo_eof;
  logic [7:0] fifo_data;
  logic       fifo_rd, tx_bit, tx_vld;

  hdlc_tx_framer u0 (
    .clk(clk), .rst_n(rst_n), .fcs_en(fcs_en), .abort_req(abort_req),
    .bit_req(bit_req), .fifo_empty(fifo_empty), .fifo_sof(fifo_sof),
    .fifo_eof(fifo_eof), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
    .tx_bit(tx_bit), .tx_vld(tx_vld)
  );

  // Show-ahead FIFO model: entry = {eof, sof, byte}
  logic [9:0] fmem [0:4095];
  int wp = 0;
  int rp = 0;
  assign fifo_empty = (rp == wp);
  assign fifo_data  = fmem[rp[11:0]][7:0];
  assign fifo_sof   = fmem[rp[11:0]][8];
  assign fifo_eof   = fmem[rp[11:0]][9];
  always @(posedge clk) if (fifo_rd) rp <= rp + 1;

  int req_pct = 100;
  always @(negedge clk) bit_req = rst_n && ($urandom_range(99) < req_pct);

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic note(bit ok, string msg);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s", msg);
    end
  endtask

  // Expected events: kind 0 = frame, 1 = abort
  int         exp_kind [0:127];
  int         exp_len  [0:127];
  int         exp_stf  [0:127];
  string      exp_tag  [0:127];
  logic [7:0] exp_dat  [0:127][0:63];
  int         n_exp = 0;
  int         n_rx  = 0;
  logic [7:0] fb [0:63];

  function automatic logic [15:0] ref_fcs(int len);
    logic [15:0] r = 16'hFFFF;
    for (int i = 0; i < len; i++)
      for (int b = 0; b < 8; b++) begin
        if (r[0] != fb[i][b]) r = (r >> 1) ^ 16'h8408;
        else                  r = r >> 1;
      end
    return r;
  endfunction

  function automatic int ref_stuffs(int k, int len);
    int run = 0;
    int cnt = 0;
    for (int i = 0; i < len; i++)
      for (int b = 0; b < 8; b++) begin
        if (exp_dat[k][i][b]) run++; else run = 0;
        if (run == 5) begin cnt++; run = 0; end
      end
    return cnt;
  endfunction

  task automatic load_fifo(int len, bit sof_first, bit eof_last);
    for (int i = 0; i < len; i++) begin
      fmem[wp[11:0]] = {(eof_last && i == len - 1), (sof_first && i == 0), fb[i]};
      wp++;
    end
  endtask

  task automatic queue_frame(int len, bit with_fcs, string tag);
    int k = n_exp;
    logic [15:0] c;
    int tot = len;
    exp_kind[k] = 0;
    exp_tag[k]  = tag;
    for (int i = 0; i < len; i++) exp_dat[k][i] = fb[i];
    if (with_fcs) begin
      c = ~ref_fcs(len);
      exp_dat[k][len]     = c[7:0];
      exp_dat[k][len + 1] = c[15:8];
      tot = len + 2;
    end
    exp_len[k] = tot;
    exp_stf[k] = ref_stuffs(k, tot);
    n_exp++;
    load_fifo(len, 1'b1, 1'b1);
  endtask

  task automatic expect_abort(string tag);
    exp_kind[n_exp] = 1;
    exp_tag[n_exp]  = tag;
    n_exp++;
  endtask

  // Line decoder: flag/abort detection and zero removal
  bit         rbits [0:1023];
  int         blen = 0;
  int         ones = 0;
  int         stf  = 0;
  bit         in_frame = 1'b0;
  int         nbits_seen = 0;
  logic [15:0] first16 = '0;

  task automatic got_frame(int nb);
    int idx = n_rx;
    bit ok;
    int bad_i = -1;
    logic [7:0] av = '0;
    logic [7:0] bv;
    n_rx++;
    if (idx >= n_exp) begin
      note(1'b0, $sformatf("R3 unexpected frame of %0d bits, expected no event", nb));
      return;
    end
    ok = (exp_kind[idx] == 0) && (nb % 8 == 0) && (nb / 8 == exp_len[idx]);
    if (ok) begin
      for (int i = 0; i < nb / 8; i++) begin
        for (int b = 0; b < 8; b++) bv[b] = rbits[i*8 + b];
        if (bad_i < 0 && bv != exp_dat[idx][i]) begin
          bad_i = i; av = bv;
        end
      end
      ok = (bad_i < 0);
    end
    note(ok, $sformatf("%s event %0d frame: bits %0d exp kind %0d len %0d; byte %0d act %02h exp %02h",
         exp_tag[idx], idx, nb, exp_kind[idx], exp_len[idx], bad_i, av,
         (bad_i >= 0) ? exp_dat[idx][bad_i] : 8'h00));
    if (exp_kind[idx] == 0)
      note(stf == exp_stf[idx], $sformatf("R2 event %0d stuffed zeros act %0d exp %0d",
           idx, stf, exp_stf[idx]));
  endtask

  task automatic got_abort();
    int idx = n_rx;
    n_rx++;
    note(idx < n_exp && exp_kind[idx] == 1,
         $sformatf("%s event %0d: act abort, exp kind %0d",
                   (idx < n_exp) ? exp_tag[idx] : "R8", idx,
                   (idx < n_exp) ? exp_kind[idx] : -1));
  endtask

  always @(negedge clk) begin
    if (rst_n && tx_vld) begin
      if (nbits_seen < 16) first16[nbits_seen] = tx_bit;
      nbits_seen++;
      if (tx_bit) begin
        ones++;
        if (blen < 1024) begin rbits[blen] = 1'b1; blen++; end
        if (ones == 7) begin
          got_abort();
          in_frame = 1'b0;
          blen = 0;
        end
      end else begin
        if (ones == 5) stf++;
        else if (ones == 6) begin
          if (in_frame && blen > 7) got_frame(blen - 7);
          in_frame = 1'b1;
          blen = 0;
          stf = 0;
        end else if (ones >= 7) blen = 0;
        else if (blen < 1024) begin rbits[blen] = 1'b0; blen++; end
        ones = 0;
      end
    end
  end

  task automatic wait_rx(int target, string tag);
    int t = 0;
    while (n_rx < target && t < 20000) begin @(negedge clk); t++; end
    if (n_rx < target)
      note(1'b0, $sformatf("%s timeout: events act %0d exp %0d", tag, n_rx, target));
  endtask

  task automatic wait_drain(string tag);
    int t = 0;
    while (rp != wp && t < 20000) begin @(negedge clk); t++; end
    note(rp == wp, $sformatf("%s FIFO not drained: rd %0d wr %0d", tag, rp, wp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog expired: events act %0d exp %0d", n_rx, n_exp);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int st0;
    int nf;
    int len;
    bit m;
    void'($urandom(32'h1A2B3C4D));
    for (int i = 0; i < 4096; i++) fmem[i] = '0;

    // R10: quiet during reset
    repeat (4) @(negedge clk);
    note(!tx_vld && !fifo_rd, $sformatf("R10 reset: tx_vld %b fifo_rd %b exp 0 0", tx_vld, fifo_rd));
    rst_n = 1'b1;

    // R1 / R10: idle flags first
    repeat (40) @(negedge clk);
    note(first16 == 16'h7E7E, $sformatf("R1 idle stream act %04h exp 7e7e", first16));
    note(n_rx == 0, $sformatf("R10 events while idle act %0d exp 0", n_rx));

    // R4: known message, generated check sequence
    for (int i = 0; i < 9; i++) fb[i] = 8'h31 + 8'(i);
    note(~ref_fcs(9) == 16'h906E, $sformatf("R4 bench check value act %04h exp 906e", ~ref_fcs(9)));
    fcs_en = 1'b1;
    queue_frame(9, 1'b1, "R4");
    wait_rx(n_exp, "R4");

    // R2: all-ones and flag-valued bytes
    for (int i = 0; i < 6; i++) fb[i] = (i % 2 == 0) ? 8'hFF : 8'h7E;
    fcs_en = 1'b0;
    queue_frame(6, 1'b0, "R2");
    wait_rx(n_exp, "R2");
    for (int i = 0; i < 4; i++) fb[i] = 8'hFF;
    fcs_en = 1'b1;
    queue_frame(4, 1'b1, "R2");
    wait_rx(n_exp, "R2");

    // R5: one-byte frame without check sequence
    fb[0] = 8'hA5;
    fcs_en = 1'b0;
    queue_frame(1, 1'b0, "R5");
    wait_rx(n_exp, "R5");

    // R6: mode change after the frame has started
    for (int i = 0; i < 8; i++) fb[i] = 8'(i * 37 + 3);
    fcs_en = 1'b1;
    st0 = rp;
    queue_frame(8, 1'b1, "R6");
    while (rp < st0 + 1) @(negedge clk);
    fcs_en = 1'b0;
    wait_rx(n_exp, "R6");
    for (int i = 0; i < 8; i++) fb[i] = 8'(i * 11 + 90);
    st0 = rp;
    queue_frame(8, 1'b0, "R6");
    while (rp < st0 + 1) @(negedge clk);
    fcs_en = 1'b1;
    wait_rx(n_exp, "R6");

    // R7: message runs out before its last byte
    for (int i = 0; i < 3; i++) fb[i] = 8'h5A;
    load_fifo(3, 1'b1, 1'b0);
    expect_abort("R7");
    wait_rx(n_exp, "R7");
    fb[0] = 8'h3C; fb[1] = 8'hC3;
    fcs_en = 1'b1;
    queue_frame(2, 1'b1, "R7");
    wait_rx(n_exp, "R7");

    // R8: abort command mid-frame, then leftovers discarded (R9)
    for (int i = 0; i < 40; i++) fb[i] = 8'($urandom);
    st0 = rp;
    load_fifo(40, 1'b1, 1'b1);
    expect_abort("R8");
    while (rp < st0 + 4) @(negedge clk);
    abort_req = 1'b1;
    @(negedge clk);
    abort_req = 1'b0;
    wait_rx(n_exp, "R8");
    wait_drain("R9");

    // R9: stray bytes without a start marker are dropped
    fb[0] = 8'h7E; fb[1] = 8'hFF;
    load_fifo(2, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) fb[i] = 8'(8'h10 + 8'(i));
    fcs_en = 1'b0;
    queue_frame(5, 1'b0, "R9");
    wait_rx(n_exp, "R9");

    // Random frames, single or back to back, varying request density
    for (int it = 0; it < 24; it++) begin
      case ($urandom_range(2))
        0: req_pct = 100;
        1: req_pct = 60;
        default: req_pct = 30;
      endcase
      m = 1'($urandom_range(1));
      fcs_en = m;
      nf = 1 + $urandom_range(1);
      for (int f = 0; f < nf; f++) begin
        len = 1 + $urandom_range(13);
        for (int i = 0; i < len; i++)
          fb[i] = ($urandom_range(3) == 0) ? 8'hFF : 8'($urandom);
        queue_frame(len, m, m ? "R3/R4" : "R3/R5");
      end
      wait_rx(n_exp, "R3");
    end

    req_pct = 100;
    repeat (60) @(negedge clk);
    note(n_rx == n_exp, $sformatf("R3 total events act %0d exp %0d", n_rx, n_exp));
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule